// File: doc/BRIEF.md
# Level-Tracking Interrupt Aggregator

This block gathers a set of interrupt request lines (32 by default) into a single interrupt output toward a processor. Each line has a pending bit that follows the line's level whenever the line changes. Each line also has an enable bit that software sets and clears through a small 32-bit register port. The output interrupt is high while at least one line is both pending and enabled.

Software reads the enabled pending lines in two ways: as a mask, or as a count of set bits. It can set or clear any group of enable bits with one write. A single write of any data to a dedicated offset clears every enable bit and every pending bit at once. Beside the register port, each line has a free-running 64-bit rising-edge counter. A debug index selects one of these counters and presents it on a separate output.

Top module: `irq_level_ctrl`

## Requirements
- R1: After reset all pending bits, enable bits and event counters are zero, `irq_out` is low and `reg_rdata` is zero.
- R2: `irq_in` is sampled on each rising clock edge. When a line's sample differs from its previous sample, its pending bit takes the new level at that edge: 1 when the line rises, 0 when it falls.
- R3: `irq_out` is high exactly when (pending AND enable) is nonzero. It reflects the state as updated by the most recent clock edge.
- R4: A read strobe (`reg_valid`=1, `reg_we`=0) at offset 0x00 returns, on `reg_rdata` after the next clock edge, the number of set bits in (pending AND enable). The value ranges from 0 to 32 and is taken from the state before that edge.
- R5: A read at offset 0x04 returns the mask (pending AND enable), with the same one-cycle latency. It does not return the raw pending value.
- R6: A write (`reg_valid`=1, `reg_we`=1) to offset 0x08 clears all enable and all pending bits, whatever the write data. A line that stays high keeps its pending bit clear until it falls and rises again. This clear wins over an input change at the same edge.
- R7: A write to offset 0x0C clears each enable bit whose write-data bit is 1 and leaves the other enable bits unchanged.
- R8: A write to offset 0x10 sets each enable bit whose write-data bit is 1 and leaves the other enable bits unchanged.
- R9: Only the exact word addresses 0x00, 0x04, 0x08, 0x0C and 0x10 are decoded. Any other address, including an unaligned one, reads as zero, and a write to it changes no state.
- R10: Each line's 64-bit counter increments once per rising transition of the line. A line held high is counted once. Counters are cleared only by reset and not by the 0x08 write. `dbg_count` shows, without a clock delay, the counter selected by `dbg_idx`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 32 | Interrupt request lines, synchronous to clk |
| reg_valid | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| irq_out | output | 1 | Aggregated interrupt toward the processor |
| dbg_idx | input | 5 | Selects the counter shown on dbg_count |
| dbg_count | output | 64 | Rising-edge count of the selected line |

## Verification
The hardest state to reach is a line that is still high while its pending bit is clear. Only the global clear produces it, and it persists until the line drops and rises again. The stimulus holds several lines high, issues the global clear, and re-enables every source to show that nothing comes back. It then toggles one line low and high to show that exactly that line returns. A second case puts a rising input and the global clear on the same edge to check which one wins. The count register is driven to its 32 boundary by moving every line from low to high at once.

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl #(
  parameter int NUM_SRC = 32,
  parameter int CNT_W   = 64,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic              reg_valid,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_out,
  input  logic [IDX_W-1:0]  dbg_idx,
  output logic [CNT_W-1:0]  dbg_count
);

  localparam logic [ADDR_W-1:0] OFS_COUNT   = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] OFS_MASK    = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] OFS_CLR_ALL = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] OFS_EN_CLR  = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] OFS_EN_SET  = ADDR_W'(8'h10);

  logic [NUM_SRC-1:0] prev_q, pend_q, en_q;
  logic [NUM_SRC-1:0] changed, rising, masked;
  logic [DATA_W-1:0]  ones;
  logic [CNT_W-1:0]   cnt_bus [NUM_SRC];

  wire wr     = reg_valid & reg_we;
  wire rd     = reg_valid & ~reg_we;
  wire clr_all = wr && (reg_addr == OFS_CLR_ALL);
  wire en_clr  = wr && (reg_addr == OFS_EN_CLR);
  wire en_set  = wr && (reg_addr == OFS_EN_SET);

  assign changed = irq_in ^ prev_q;
  assign rising  = irq_in & ~prev_q;
  assign masked  = pend_q & en_q;
  assign irq_out = |masked;

  always_comb begin
    ones = '0;
    for (int i = 0; i < NUM_SRC; i++) ones = ones + DATA_W'(masked[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
      en_q   <= '0;
    end else begin
      prev_q <= irq_in;
      if (clr_all) pend_q <= '0;
      else         pend_q <= (pend_q & ~changed) | (irq_in & changed);
      if (clr_all)     en_q <= '0;
      else if (en_clr) en_q <= en_q & ~reg_wdata[NUM_SRC-1:0];
      else if (en_set) en_q <= en_q | reg_wdata[NUM_SRC-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) reg_rdata <= '0;
    else if (rd) begin
      case (reg_addr)
        OFS_COUNT: reg_rdata <= ones;
        OFS_MASK:  reg_rdata <= DATA_W'(masked);
        default:   reg_rdata <= '0;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_cnt
    logic [CNT_W-1:0] cnt_q;
    always_ff @(posedge clk) begin
      if (!rst_n)         cnt_q <= '0;
      else if (rising[g]) cnt_q <= cnt_q + 1'b1;
    end
    assign cnt_bus[g] = cnt_q;
  end

  assign dbg_count = cnt_bus[dbg_idx];

endmodule

module irq_level_ctrl_chk #(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] irq_in,
  input logic               reg_valid,
  input logic               reg_we,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic [DATA_W-1:0]  reg_wdata,
  input logic [DATA_W-1:0]  reg_rdata,
  input logic               irq_out,
  input logic [NUM_SRC-1:0] pend,
  input logic [NUM_SRC-1:0] en,
  input logic [NUM_SRC-1:0] prev
);
  wire wr = reg_valid && reg_we;
  wire rd = reg_valid && !reg_we;
  wire a_clr = wr && reg_addr == ADDR_W'(8'h08);
  wire a_dis = wr && reg_addr == ADDR_W'(8'h0C);
  wire a_en  = wr && reg_addr == ADDR_W'(8'h10);
  wire rd_unmapped = rd && reg_addr != ADDR_W'(8'h00) && reg_addr != ADDR_W'(8'h04);
  wire wr_unmapped = wr && !a_clr && !a_dis && !a_en;

  AST_GLOBAL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) a_clr |=> (en == '0 && pend == '0 && !irq_out)); // R6
  AST_EN_CLR_BITS: assert property (@(posedge clk) disable iff (!rst_n) a_dis |=> ((en & $past(reg_wdata[NUM_SRC-1:0])) == '0)); // R7
  AST_EN_SET_BITS: assert property (@(posedge clk) disable iff (!rst_n) a_en |=> ((en & $past(reg_wdata[NUM_SRC-1:0])) == $past(reg_wdata[NUM_SRC-1:0]))); // R8
  AST_RISE_PENDS: assert property (@(posedge clk) disable iff (!rst_n) (!a_clr && |(irq_in & ~prev)) |=> ((pend & $past(irq_in & ~prev)) == $past(irq_in & ~prev))); // R2
  AST_FALL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (|(~irq_in & prev)) |=> ((pend & $past(~irq_in & prev)) == '0)); // R2
  AST_COUNT_READ: assert property (@(posedge clk) disable iff (!rst_n) (rd && reg_addr == ADDR_W'(8'h00)) |=> (reg_rdata == DATA_W'($countones($past(pend & en))))); // R4
  AST_UNMAPPED_READ: assert property (@(posedge clk) disable iff (!rst_n) rd_unmapped |=> (reg_rdata == '0)); // R9
  AST_UNMAPPED_WRITE: assert property (@(posedge clk) disable iff (!rst_n) wr_unmapped |=> (en == $past(en))); // R9
endmodule

bind irq_level_ctrl irq_level_ctrl_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_valid(reg_valid), .reg_we(reg_we),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out),
  .pend(pend_q), .en(en_q), .prev(prev_q)
);

// File: tb/test_irq_level_ctrl.sv
`timescale 1ns/1ps
module test_irq_level_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_in = '0;
  logic        reg_valid = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_out;
  logic [4:0]  dbg_idx = '0;
  logic [63:0] dbg_count;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  irq_level_ctrl i_irq_level_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_valid(reg_valid), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out),
    .dbg_idx(dbg_idx), .dbg_count(dbg_count)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(logic [7:0] a, logic [31:0] d);
    reg_valid = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_valid = 1'b0; reg_we = 1'b0;
  endtask

  task automatic reg_read(logic [7:0] a, output logic [31:0] d);
    reg_valid = 1'b1; reg_we = 1'b0; reg_addr = a;
    tick();
    reg_valid = 1'b0;
    d = reg_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 irq_out", 64'(irq_out), 0);
    check("R1 rdata", 64'(reg_rdata), 0);
    reg_read(8'h00, v); check("R1 count", 64'(v), 0);
    reg_read(8'h04, v); check("R1 mask", 64'(v), 0);
    dbg_idx = 5'd5; #1;
    check("R1 counter", dbg_count, 0);
  endtask

  task automatic t_level();
    logic [31:0] v;
    irq_in = 32'h0000_00F0; tick();
    check("R3 no enable", 64'(irq_out), 0);
    reg_write(8'h10, 32'h30);
    check("R3 irq_out high", 64'(irq_out), 1);
    reg_read(8'h04, v); check("R5 masked", 64'(v), 64'h30);
    reg_read(8'h00, v); check("R4 count", 64'(v), 2);
    irq_in = 32'h0000_00E0; tick();
    reg_read(8'h04, v); check("R2 fall clears", 64'(v), 64'h20);
    reg_write(8'h10, 32'hFFFF_0000);
    reg_read(8'h04, v); check("R8 set keeps others", 64'(v), 64'h20);
  endtask

  task automatic t_disable();
    logic [31:0] v;
    reg_write(8'h0C, 32'h20);
    reg_read(8'h04, v); check("R7 clear bit", 64'(v), 0);
    check("R3 irq_out low", 64'(irq_out), 0);
    reg_write(8'h10, 32'h40);
    reg_read(8'h04, v); check("R7 others kept", 64'(v), 64'h40);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    reg_write(8'h14, 32'hFFFF_FFFF);
    reg_write(8'h0E, 32'h40);
    reg_write(8'h11, 32'hFF);
    reg_write(8'h09, 32'h0);
    reg_read(8'h04, v); check("R9 writes ignored", 64'(v), 64'h40);
    reg_read(8'h14, v); check("R9 read 0x14", 64'(v), 0);
    reg_read(8'h08, v); check("R9 read 0x08", 64'(v), 0);
    reg_read(8'h10, v); check("R9 read 0x10", 64'(v), 0);
    reg_read(8'h05, v); check("R9 read unaligned", 64'(v), 0);
  endtask

  task automatic t_global();
    logic [31:0] v;
    reg_write(8'h08, 32'h0);
    check("R6 irq_out", 64'(irq_out), 0);
    reg_write(8'h10, 32'hFFFF_FFFF);
    reg_read(8'h04, v); check("R6 held line stays clear", 64'(v), 0);
    irq_in = 32'h0000_00C0; tick();
    irq_in = 32'h0000_00E0; tick();
    reg_read(8'h04, v); check("R6 re-rise returns", 64'(v), 64'h20);
    irq_in = 32'h0000_01E0;
    reg_write(8'h08, 32'hDEAD_BEEF);
    reg_write(8'h10, 32'hFFFF_FFFF);
    reg_read(8'h04, v); check("R6 wins same edge", 64'(v), 0);
    irq_in = '0; tick();
    irq_in = '1; tick();
    reg_read(8'h00, v); check("R4 count 32", 64'(v), 32);
    reg_read(8'h04, v); check("R5 all", 64'(v), 64'hFFFF_FFFF);
    irq_in = '0; tick();
    check("R2 all fall", 64'(irq_out), 0);
  endtask

  task automatic t_counter();
    logic [63:0] base;
    dbg_idx = 5'd3; #1;
    base = dbg_count;
    for (int k = 0; k < 3; k++) begin
      irq_in[3] = 1'b1; repeat (4) tick();
      irq_in[3] = 1'b0; tick();
    end
    check("R10 three rises", dbg_count, base + 3);
    reg_write(8'h08, 32'h0);
    check("R10 kept on clear", dbg_count, base + 3);
    dbg_idx = 5'd31; #1;
    check("R10 index 31", dbg_count, 64'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_level();
    t_disable();
    t_unmapped();
    t_global();
    t_counter();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule